// File: doc/BRIEF.md
# Rotate-and-Mask Unit

This block is the combinational rotate-and-mask datapath of a 64-bit integer execution unit. It takes a source operand and rotates it left. It then builds a contiguous mask, which may wrap, from a begin field and an end field. The rotated value is either ANDed with the mask or merged under the mask into the destination's previous value. One operation select chooses among three 32-bit ("word") forms and three 64-bit ("doubleword") forms.

Bit positions in the mask fields use MSB-first numbering: position 0 is result bit 63 and position 63 is result bit 0.

The word forms copy the low 32 bits of the source into both halves before the 64-bit rotate. They also offset both mask fields by 32, so the mask lands in the low word unless it wraps.

The block has no clock and no state. It sits between operand fetch and writeback, and the result settles one combinational delay after the inputs change. There is no stream interface, so back-pressure does not apply: the surrounding pipeline registers the operands and the result.

Top module: `rotmask_unit`

## Requirements
- R1: Word forms (op codes 0, 1, 2) use only `src_val[31:0]`, replicated into both 32-bit halves before rotation. `src_val[63:32]` has no effect on their result.
- R2: Op codes 0 and 2 rotate left by `amt_imm[4:0]`. Op codes 3, 4 and 5 rotate left by all 6 bits of `amt_imm`. Rotation preserves every bit of the rotated value.
- R3: Op code 1 rotates left by `amt_reg[4:0]` only. `amt_reg[63:5]` has no effect.
- R4: The mask sets MSB-first positions lo..hi, where position p is result bit 63-p, whenever lo <= hi. Op codes 0, 1, 3, 4 and 5 output the rotated value ANDed with the mask.
- R5: When lo > hi, the mask wraps: it sets positions lo..63 and 0..hi.
- R6: For word forms, lo = 32 + `mb_fld[4:0]` and hi = 32 + `me_fld[4:0]`. For example, rotate 0x8fffffff by 1 with fields 31,31 gives 1.
- R7: Op code 2 (insert) outputs rotated bits inside the mask and `dst_old` bits outside it. For example, rotate 0xcc by 16 with fields 8,15 into 0x7f00ffff gives 0x7fccffff.
- R8: Op code 3 (clear) uses lo = `mb_fld` and hi = 63 - `amt_imm`.
- R9: Op code 4 (clear-left) uses lo = `mb_fld` and hi = 63.
- R10: Op code 5 (clear-right) uses lo = 0 and hi = `me_fld`.
- R11: Op codes 6 and 7 output zero.
- R12: `dst_old` has no effect on any op code other than 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (0 word-imm AND, 1 word-reg AND, 2 word-imm insert, 3 dw clear, 4 dw clear-left, 5 dw clear-right) |
| src_val | input | 64 | Source operand to rotate |
| dst_old | input | 64 | Previous destination value, merged by insert |
| amt_imm | input | 6 | Immediate rotate amount |
| amt_reg | input | 64 | Register rotate amount (low 5 bits used) |
| mb_fld | input | 6 | Mask begin field (MSB-first) |
| me_fld | input | 6 | Mask end field (MSB-first) |
| result | output | 64 | Rotated and masked result |

## Verification
On every input change, the assertions check three things.

- The mask's population count matches its begin and end fields, in both the plain and the wrapped case.
- Rotation never changes the number of set bits, and a replicated word stays replicated after the rotate.
- Insert keeps `dst_old` outside the mask, the AND forms zero everything outside it, and the unused op codes give zero.

Whether the mask sits at the right positions, whether the rotate moved by the right amount, and how each op code derives its fields can only be shown by the bench. It sweeps every begin/end pair and rotate amount against an arithmetic reference model.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  typedef enum logic [2:0] {
    OP_W_IMM_AND = 3'd0,
    OP_W_REG_AND = 3'd1,
    OP_W_IMM_INS = 3'd2,
    OP_D_CLR     = 3'd3,
    OP_D_CLR_LO  = 3'd4,
    OP_D_CLR_HI  = 3'd5
  } rm_op_e;

endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int W  = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [0:AW];

  assign stage[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][W-1-K:0], stage[s][W-1:W-K]} : stage[s];
  end

  assign dout = stage[AW];

  always_comb begin
    AST_ROT_KEEPS_ONES: assert ($countones(dout) == $countones(din))
      else $error("rotation changed population count"); // R2
  end

endmodule

// File: rtl/rm_mask_gen.sv
module rm_mask_gen #(
  parameter int W  = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [W-1:0]  mask
);

  logic wrap;
  assign wrap = lo > hi;

  for (genvar j = 0; j < W; j++) begin : g_bit
    localparam logic [AW-1:0] POS = AW'(W - 1 - j);
    logic ge_lo, le_hi;
    assign ge_lo = POS >= lo;
    assign le_hi = POS <= hi;
    assign mask[j] = wrap ? (ge_lo | le_hi) : (ge_lo & le_hi);
  end

  always_comb begin
    if (!wrap) begin
      AST_MASK_SPAN: assert ($countones(mask) == (int'(hi) - int'(lo) + 1))
        else $error("plain mask width mismatch"); // R4
    end else begin
      AST_MASK_WRAP_SPAN: assert ($countones(mask) == (W - int'(lo) + int'(hi) + 1))
        else $error("wrapped mask width mismatch"); // R5
    end
  end

endmodule

// File: rtl/rm_decode.sv
module rm_decode
  import rotmask_pkg::*;
#(
  parameter int W  = 64,
  localparam int AW = $clog2(W),
  localparam int HW = W / 2
) (
  input  logic [2:0]    op_sel,
  input  logic [W-1:0]  src_val,
  input  logic [AW-1:0] amt_imm,
  input  logic [AW-2:0] amt_reg_lo,
  input  logic [AW-1:0] mb_fld,
  input  logic [AW-1:0] me_fld,
  output logic [W-1:0]  rot_src,
  output logic [AW-1:0] rot_amt,
  output logic [AW-1:0] mask_lo,
  output logic [AW-1:0] mask_hi,
  output logic          is_word,
  output logic          is_ins,
  output logic          is_known
);

  rm_op_e op_e;
  assign op_e = rm_op_e'(op_sel);

  always_comb begin
    rot_src  = src_val;
    rot_amt  = amt_imm;
    mask_lo  = mb_fld;
    mask_hi  = me_fld;
    is_word  = 1'b0;
    is_ins   = 1'b0;
    is_known = 1'b1;
    case (op_e)
      OP_W_IMM_AND, OP_W_REG_AND, OP_W_IMM_INS: begin
        is_word = 1'b1;
        is_ins  = (op_e == OP_W_IMM_INS);
        rot_src = {2{src_val[HW-1:0]}};
        rot_amt = {1'b0, (op_e == OP_W_REG_AND) ? amt_reg_lo : amt_imm[AW-2:0]};
        mask_lo = {1'b1, mb_fld[AW-2:0]};
        mask_hi = {1'b1, me_fld[AW-2:0]};
      end
      OP_D_CLR:    mask_hi = AW'(W - 1) - amt_imm;
      OP_D_CLR_LO: mask_hi = AW'(W - 1);
      OP_D_CLR_HI: mask_lo = '0;
      default:     is_known = 1'b0;
    endcase
  end

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int W  = 64,
  localparam int AW = $clog2(W),
  localparam int HW = W / 2
) (
  input  logic [2:0]    op_sel,
  input  logic [W-1:0]  src_val,
  input  logic [W-1:0]  dst_old,
  input  logic [AW-1:0] amt_imm,
  input  logic [W-1:0]  amt_reg,
  input  logic [AW-1:0] mb_fld,
  input  logic [AW-1:0] me_fld,
  output logic [W-1:0]  result
);

  logic [W-1:0]  rot_src, rotated, mask;
  logic [AW-1:0] rot_amt, mask_lo, mask_hi;
  logic          is_word, is_ins, is_known;
  logic          unused_amt_hi;

  assign unused_amt_hi = ^amt_reg[W-1:AW-1];

  rm_decode #(.W(W)) u_dec (
    .op_sel    (op_sel),
    .src_val   (src_val),
    .amt_imm   (amt_imm),
    .amt_reg_lo(amt_reg[AW-2:0]),
    .mb_fld    (mb_fld),
    .me_fld    (me_fld),
    .rot_src   (rot_src),
    .rot_amt   (rot_amt),
    .mask_lo   (mask_lo),
    .mask_hi   (mask_hi),
    .is_word   (is_word),
    .is_ins    (is_ins),
    .is_known  (is_known)
  );

  rm_rotator #(.W(W)) u_rot (
    .din (rot_src),
    .amt (rot_amt),
    .dout(rotated)
  );

  rm_mask_gen #(.W(W)) u_mask (
    .lo  (mask_lo),
    .hi  (mask_hi),
    .mask(mask)
  );

  always_comb begin
    if (!is_known)   result = '0;
    else if (is_ins) result = (rotated & mask) | (dst_old & ~mask);
    else             result = rotated & mask;
  end

  always_comb begin
    if (is_word) begin
      AST_WORD_STAYS_REPLICATED: assert (rotated[W-1:HW] == rotated[HW-1:0])
        else $error("word rotate lost replication"); // R1
    end
    if (op_sel == 3'd2) begin
      AST_INS_KEEPS_OLD: assert (((result ^ dst_old) & ~mask) == '0)
        else $error("insert altered bits outside mask"); // R7
    end
    if (op_sel <= 3'd5 && op_sel != 3'd2) begin
      AST_AND_CLEARS_OUTSIDE: assert ((result & ~mask) == '0)
        else $error("AND form leaked bits outside mask"); // R4
    end
    if (op_sel > 3'd5) begin
      AST_BAD_OP_ZERO: assert (result == '0)
        else $error("unused op code gave nonzero result"); // R11
    end
  end

endmodule

// File: tb/rotmask_unit_test.sv
module rotmask_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel;
  logic [63:0] src_val, dst_old, amt_reg, result;
  logic [5:0]  amt_imm, mb_fld, me_fld;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  rotmask_unit uut (
    .op_sel (op_sel),
    .src_val(src_val),
    .dst_old(dst_old),
    .amt_imm(amt_imm),
    .amt_reg(amt_reg),
    .mb_fld (mb_fld),
    .me_fld (me_fld),
    .result (result)
  );

  function automatic logic [63:0] rotl(input logic [63:0] x, input int n);
    if (n == 0) return x;
    return (x << n) | (x >> (64 - n));
  endfunction

  function automatic logic [63:0] mk_mask(input int lo, input int hi);
    logic [63:0] from_lo, to_hi;
    from_lo = 64'hffff_ffff_ffff_ffff >> lo;
    to_hi   = 64'hffff_ffff_ffff_ffff << (63 - hi);
    return (lo <= hi) ? (from_lo & to_hi) : (from_lo | to_hi);
  endfunction

  function automatic logic [63:0] model(input int op, input logic [63:0] s, input logic [63:0] o,
                                        input int imm, input logic [63:0] rg, input int mb, input int me);
    logic [63:0] w, r, m;
    w = {s[31:0], s[31:0]};
    case (op)
      0: begin r = rotl(w, imm % 32); m = mk_mask(32 + mb % 32, 32 + me % 32); return r & m; end
      1: begin r = rotl(w, int'(rg[4:0])); m = mk_mask(32 + mb % 32, 32 + me % 32); return r & m; end
      2: begin r = rotl(w, imm % 32); m = mk_mask(32 + mb % 32, 32 + me % 32); return (r & m) | (o & ~m); end
      3: return rotl(s, imm) & mk_mask(mb, 63 - imm);
      4: return rotl(s, imm) & mk_mask(mb, 63);
      5: return rotl(s, imm) & mk_mask(0, me);
      default: return 64'h0;
    endcase
  endfunction

  task automatic run(input string tag, input int op, input logic [63:0] s, input logic [63:0] o,
                     input int imm, input logic [63:0] rg, input int mb, input int me,
                     input logic [63:0] exp);
    @(posedge clk);
    op_sel = 3'(op); src_val = s; dst_old = o; amt_imm = 6'(imm);
    amt_reg = rg; mb_fld = 6'(mb); me_fld = 6'(me);
    @(negedge clk);
    total++;
    if (result !== exp) begin
      bad++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, op, result, exp);
    end
  endtask

  task automatic run_m(input string tag, input int op, input logic [63:0] s, input logic [63:0] o,
                       input int imm, input logic [63:0] rg, input int mb, input int me);
    run(tag, op, s, o, imm, rg, mb, me, model(op, s, o, imm, rg, mb, me));
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    op_sel = 3'd0; src_val = '0; dst_old = '0; amt_imm = '0; amt_reg = '0; mb_fld = '0; me_fld = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (result !== 64'h0) begin
      bad++;
      $display("FAIL R4 idle got=%h exp=%h", result, 64'h0);
    end

    // Directed values
    run("R6", 0, 64'h8fffffff, 0, 1, 0, 31, 31, 64'h1);
    run("R6", 0, 64'hebeb1888, 0, 0, 0, 16, 31, 64'h1888);
    run("R3", 1, 64'hfebaacda, 0, 0, 64'd16, 8, 11, 64'hd00000);
    run("R1", 1, 64'h11faafff1111aa11, 0, 0, 64'd11, 16, 20, 64'h8800);
    run("R7", 2, 64'h1, 64'h7fffffff, 31, 0, 0, 0, 64'hffffffff);
    run("R7", 2, 64'hcc, 64'h7f00ffff, 16, 0, 8, 15, 64'h7fccffff);
    run("R3", 1, 64'h111, 0, 0, 64'd1, 0, 31, 64'h222);
    run("R8", 3, 64'h0100ffff00000111, 0, 8, 0, 31, 0, 64'h11100);
    run("R8", 3, 64'h0100ffff00000fff, 0, 0, 0, 51, 0, 64'hfff);
    run("R9", 4, 64'h0100ffff00000111, 0, 8, 0, 44, 0, 64'h11101);
    run("R9", 4, 64'h1000dead0000111c, 0, 32, 0, 47, 0, 64'hdead);
    run("R10", 5, 64'h0100ffffe0000111, 0, 16, 0, 0, 15, 64'hffff000000000000);
    run("R10", 5, 64'h1000caef0000dead, 0, 32, 0, 0, 32, 64'hdead00000000);
    run("R5", 0, 64'h0000_0000_ffff_ffff, 0, 0, 0, 31, 0, 64'hffff_ffff_8000_0001 & 64'hffff_ffff_ffff_ffff);
    run("R11", 6, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 5, 64'h5, 3, 9, 64'h0);
    run("R11", 7, 64'h1234_5678_9abc_def0, 64'hffff_ffff_ffff_ffff, 0, 0, 0, 63, 64'h0);

    // Word AND, all field pairs (plain and wrapped), upper source noise
    for (int sh = 0; sh < 32; sh += 13)
      for (int mb = 0; mb < 32; mb++)
        for (int me = 0; me < 32; me++)
          run_m((mb > me) ? "R5" : "R4", 0, 64'hdead_beef_1234_5679, 64'hffff_ffff_ffff_ffff,
                sh + ((mb & 1) << 5), 0, mb + ((me & 1) << 5), me);

    // Word register form: amount from low 5 bits only
    for (int k = 0; k < 32; k++)
      for (int noise = 0; noise < 4; noise++)
        run_m("R3", 1, 64'h0f0f_a5a5_8001_c3b7, 0, 0,
              (64'(noise) * 64'h5555_5555_5555_5540) | 64'(k), 3, 28);

    // Word insert, all field pairs
    for (int mb = 0; mb < 32; mb++)
      for (int me = 0; me < 32; me++)
        run_m("R7", 2, 64'hffff_0000_9c3a_61e5, 64'h5a5a_5a5a_0f0f_0f0f, 13, 0, mb, me);

    // Doubleword clear: all shifts and begin fields, old value noise
    for (int sh = 0; sh < 64; sh++)
      for (int mb = 0; mb < 64; mb++)
        run_m("R8", 3, 64'h8123_4567_89ab_cdef, (sh & 1) ? 64'hffff_ffff_ffff_ffff : 64'h0, sh, 0, mb, 0);

    // Clear-left and clear-right sweeps
    for (int sh = 0; sh < 64; sh++)
      for (int f = 0; f < 64; f++) begin
        run_m("R9", 4, 64'hc0de_1357_2468_f00d, 64'h0, sh, 0, f, 0);
        run_m("R10", 5, 64'hc0de_1357_2468_f00d, 64'hffff_ffff_ffff_ffff, sh, 0, 0, f);
      end

    // dst_old ignored by non-insert forms
    for (int op = 0; op < 6; op++)
      if (op != 2) begin
        run_m("R12", op, 64'h7777_1111_abcd_4321, 64'h0, 9, 64'd9, 5, 40);
        run_m("R12", op, 64'h7777_1111_abcd_4321, 64'hffff_ffff_ffff_ffff, 9, 64'd9, 5, 40);
      end

    // Full 6-bit immediate on doubleword forms
    run("R2", 4, 64'h1, 0, 63, 0, 0, 0, 64'h8000_0000_0000_0000);
    run("R2", 0, 64'h1, 0, 33, 0, 0, 31, 64'h2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule